// File: doc/BRIEF.md
# Memory Error Response Handler

This block sits between a requester and a protected storage array. It decides what happens to each access when the stored data fails its integrity check. Every request presents the stored word, a correction flip mask, and one check outcome for each protection granule. The outcome is clean, correctable or uncorrectable; the code that produces it lies outside the block. From these inputs the handler builds the data to return or to write back, a set of per-granule poison markers, per-granule write enables for the array, a two-bit response code, and a one-cycle event for an error record.

Reads return one of four things: good data, corrected data, data marked as poisoned, or an in-band error. Writes whose strobes cover part of a granule merge the new bytes over the corrected old bytes. If the old bytes are uncorrectable, the granule is poisoned. Dirty evictions always defer an uncorrectable error by poisoning, and never abort. Uncorrectable errors follow an ordered choice: correct if possible, otherwise defer by poisoning if deferral is enabled, otherwise raise an in-band error if that response is enabled. If neither is enabled, poisoned data is the fallback.

Top module: `mer_resp_unit`

## Requirements
- R1: A request whose granules all check clean (check code 00) returns response code 00 with unmodified data, no poison and no event. Operation codes are 00 read, 01 write, 10 eviction. Granule i holds data bits [32i+31:32i] and strobes [4i+3:4i].
- R2: A read of a granule with check code 01 (correctable) returns that granule as stored data XOR the flip mask. The response code is 01, and an event of class 01 (CE) is raised.
- R3: A read of a granule with an uncorrectable check (code 10, and code 11 is treated the same) returns the stored data unchanged when deferral is enabled. That granule's poison bit is set, the response code is 10, and the event class is 10 (DE).
- R4: A read with an uncorrectable granule, deferral disabled and in-band errors enabled returns response code 11. That granule's data is forced to zero and the event class is 11 (UE).
- R5: With both deferral and in-band errors disabled, an uncorrectable read granule is returned poisoned with response code 10, and the event class is UE.
- R6: A write whose strobes cover part of a correctable granule writes the new bytes merged over the corrected old bytes. It sets that granule's write enable, gives response code 01 and raises a CE event.
- R7: A partial write over an uncorrectable granule, with deferral enabled or in-band errors disabled, writes the merged bytes with poison set and gives response code 10.
- R8: A partial write over an uncorrectable granule, with deferral disabled and in-band errors enabled, drops that granule (write enable 0, data zero), returns code 11 and raises a UE event.
- R9: On a write, the check outcome is ignored for a granule that is fully strobed (written with new data, code 00) and for a granule with no strobes (not written, data passes through as stored).
- R10: On a dirty eviction, an uncorrectable granule is always written out poisoned with code 10 and class DE, even when deferral is disabled and in-band errors are enabled.
- R11: On an eviction with the dirty flag low, nothing is written, no event is raised and the response code is 00, whatever the check outcome.
- R12: When granules differ, the response code is the highest granule code, and one event carries the highest granule class.
- R13: Results appear exactly one clock after the request. Without a request, the response valid, code, poison, write enables and event are all zero, including straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 eviction |
| req_dirty | input | 1 | Evicted line holds modified data |
| req_wstrb | input | DW/8 | Byte strobes of a write |
| req_wdata | input | DW | Write data |
| req_odata | input | DW | Stored data read from the array |
| req_fix | input | DW | Correction flip mask for correctable granules |
| req_chk | input | 2*DW/GW | Check outcome per granule: 00 clean, 01 correctable, 1x uncorrectable |
| defer_en | input | 1 | Allow deferral by poisoning |
| ierr_en | input | 1 | Allow in-band error responses |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 OK, 01 corrected, 10 poisoned, 11 in-band error |
| rsp_data | output | DW | Returned or written-back data |
| rsp_poison | output | DW/GW | Poison marker per granule |
| rsp_gwe | output | DW/GW | Array write enable per granule |
| evt_valid | output | 1 | One-cycle error-record event |
| evt_class | output | 2 | Event class: 01 CE, 10 DE, 11 UE |

## Verification
Two granules of one access can take different outcomes in the same cycle. For example, one can be corrected while the other is deferred or aborted. The code and event combination must then pick the worst case and still raise only one event. Directed requests pair a correctable granule with an uncorrectable one, and a long random run mixes all outcome pairs under every enable setting. A behavioural model in the bench predicts every output field, and the bench compares it against the design on each falling edge.

// File: rtl/mer_pkg.sv
package mer_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_EVICT = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CHK_CLEAN  = 2'b00,
    CHK_CORR   = 2'b01,
    CHK_UNCORR = 2'b10,
    CHK_RSVD   = 2'b11
  } chk_e;

  // numeric order follows severity, so the worst is the maximum
  typedef enum logic [1:0] {
    RSP_OK     = 2'b00,
    RSP_FIXED  = 2'b01,
    RSP_POISON = 2'b10,
    RSP_ABORT  = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_CE   = 2'b01,
    CLS_DE   = 2'b10,
    CLS_UE   = 2'b11
  } cls_e;

  typedef struct packed {
    rsp_e code;
    cls_e cls;
    logic poison;
    logic we;
  } gran_res_t;

endpackage

// File: rtl/mer_gran_eval.sv
module mer_gran_eval
  import mer_pkg::*;
#(
  parameter int GW = 32
) (
  input  op_e              op,
  input  logic             dirty,
  input  logic [GW/8-1:0]  strb,
  input  logic [GW-1:0]    wdata,
  input  logic [GW-1:0]    odata,
  input  logic [GW-1:0]    fix,
  input  chk_e             chk,
  input  logic             defer_en,
  input  logic             ierr_en,
  output gran_res_t        res,
  output logic [GW-1:0]    data
);

  localparam int BPG = GW / 8;

  logic [GW-1:0] fixed_old;
  logic [GW-1:0] merged;
  logic          unc;
  logic          full_wr;
  logic          no_wr;

  always_comb begin
    fixed_old = (chk == CHK_CORR) ? (odata ^ fix) : odata;
    for (int b = 0; b < BPG; b++) begin
      merged[b*8 +: 8] = strb[b] ? wdata[b*8 +: 8] : fixed_old[b*8 +: 8];
    end
    unc     = chk[1];
    full_wr = &strb;
    no_wr   = ~|strb;
  end

  always_comb begin
    res.code = RSP_OK;
    res.cls  = CLS_NONE;
    res.we   = 1'b0;
    data     = fixed_old;
    unique case (op)
      OP_WRITE: begin
        if (no_wr) begin
          data = odata;
        end else if (full_wr) begin
          res.we = 1'b1;
          data   = wdata;
        end else begin
          res.we = 1'b1;
          data   = merged;
          if (chk == CHK_CORR) begin
            res.code = RSP_FIXED;
            res.cls  = CLS_CE;
          end else if (unc) begin
            if (defer_en) begin
              res.code = RSP_POISON;
              res.cls  = CLS_DE;
            end else if (ierr_en) begin
              res.code = RSP_ABORT;
              res.cls  = CLS_UE;
              res.we   = 1'b0;
              data     = '0;
            end else begin
              res.code = RSP_POISON;
              res.cls  = CLS_UE;
            end
          end
        end
      end
      OP_EVICT: begin
        if (dirty) begin
          res.we = 1'b1;
          if (chk == CHK_CORR) begin
            res.code = RSP_FIXED;
            res.cls  = CLS_CE;
          end else if (unc) begin
            res.code = RSP_POISON;
            res.cls  = CLS_DE;
          end
        end else begin
          data = odata;
        end
      end
      default: begin
        if (chk == CHK_CORR) begin
          res.code = RSP_FIXED;
          res.cls  = CLS_CE;
        end else if (unc) begin
          if (defer_en) begin
            res.code = RSP_POISON;
            res.cls  = CLS_DE;
          end else if (ierr_en) begin
            res.code = RSP_ABORT;
            res.cls  = CLS_UE;
            data     = '0;
          end else begin
            res.code = RSP_POISON;
            res.cls  = CLS_UE;
          end
        end
      end
    endcase
    res.poison = (res.code == RSP_POISON);
  end

endmodule

// File: rtl/mer_reduce.sv
module mer_reduce
  import mer_pkg::*;
#(
  parameter int NG = 2
) (
  input  logic [NG-1:0][1:0] codes,
  input  logic [NG-1:0][1:0] classes,
  output rsp_e               worst_code,
  output cls_e               worst_cls
);

  logic [1:0] c_acc;
  logic [1:0] k_acc;

  always_comb begin
    c_acc = 2'b00;
    k_acc = 2'b00;
    for (int g = 0; g < NG; g++) begin
      if (codes[g] > c_acc)   c_acc = codes[g];
      if (classes[g] > k_acc) k_acc = classes[g];
    end
    worst_code = rsp_e'(c_acc);
    worst_cls  = cls_e'(k_acc);
  end

endmodule

// File: rtl/mer_resp_unit.sv
module mer_resp_unit
  import mer_pkg::*;
#(
  parameter int DW = 64,
  parameter int GW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic                 req_dirty,
  input  logic [DW/8-1:0]      req_wstrb,
  input  logic [DW-1:0]        req_wdata,
  input  logic [DW-1:0]        req_odata,
  input  logic [DW-1:0]        req_fix,
  input  logic [2*DW/GW-1:0]   req_chk,
  input  logic                 defer_en,
  input  logic                 ierr_en,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [DW-1:0]        rsp_data,
  output logic [DW/GW-1:0]     rsp_poison,
  output logic [DW/GW-1:0]     rsp_gwe,
  output logic                 evt_valid,
  output logic [1:0]           evt_class
);

  localparam int NG  = DW / GW;
  localparam int BPG = GW / 8;

  logic [NG-1:0][1:0] g_code;
  logic [NG-1:0][1:0] g_cls;
  logic [NG-1:0]      g_poison;
  logic [NG-1:0]      g_we;
  logic [DW-1:0]      g_data;
  rsp_e               w_code;
  cls_e               w_cls;

  for (genvar g = 0; g < NG; g++) begin : gen_gran
    gran_res_t r;
    mer_gran_eval #(.GW(GW)) u_eval (
      .op       (op_e'(req_op)),
      .dirty    (req_dirty),
      .strb     (req_wstrb[g*BPG +: BPG]),
      .wdata    (req_wdata[g*GW +: GW]),
      .odata    (req_odata[g*GW +: GW]),
      .fix      (req_fix[g*GW +: GW]),
      .chk      (chk_e'(req_chk[g*2 +: 2])),
      .defer_en (defer_en),
      .ierr_en  (ierr_en),
      .res      (r),
      .data     (g_data[g*GW +: GW])
    );
    assign g_code[g]   = r.code;
    assign g_cls[g]    = r.cls;
    assign g_poison[g] = r.poison;
    assign g_we[g]     = r.we;
  end

  mer_reduce #(.NG(NG)) u_reduce (
    .codes      (g_code),
    .classes    (g_cls),
    .worst_code (w_code),
    .worst_cls  (w_cls)
  );

  // next-state
  logic          nx_valid;
  logic [1:0]    nx_code;
  logic [NG-1:0] nx_poison;
  logic [NG-1:0] nx_gwe;
  logic          nx_evt;
  logic [1:0]    nx_cls;

  always_comb begin
    nx_valid  = req_valid;
    nx_code   = req_valid ? w_code   : 2'b00;
    nx_poison = req_valid ? g_poison : '0;
    nx_gwe    = req_valid ? g_we     : '0;
    nx_evt    = req_valid && (w_cls != CLS_NONE);
    nx_cls    = nx_evt ? w_cls : 2'b00;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= 2'b00;
      rsp_poison <= '0;
      rsp_gwe    <= '0;
      evt_valid  <= 1'b0;
      evt_class  <= 2'b00;
    end else begin
      rsp_valid  <= nx_valid;
      rsp_code   <= nx_code;
      rsp_poison <= nx_poison;
      rsp_gwe    <= nx_gwe;
      evt_valid  <= nx_evt;
      evt_class  <= nx_cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (req_valid) begin
      rsp_data <= g_data;
    end
  end

  // assertions
  a_r13_evt_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> rsp_valid);

  a_r10_evict_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op) == OP_EVICT) |-> rsp_code != RSP_ABORT);

  a_r4_abort_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RSP_ABORT) |-> ($past(ierr_en) && !$past(defer_en)));

  a_r2_ce_is_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_class == CLS_CE) |-> rsp_code == RSP_FIXED);

  a_r3_poison_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && |rsp_poison) |-> rsp_code[1]);

  a_r12_code_needs_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RSP_OK) |-> evt_valid);

endmodule

// File: tb/mer_resp_unit_tb.sv
module mer_resp_unit_tb_top;

  localparam int DW = 64;
  localparam int GW = 32;
  localparam int NG = DW / GW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = 2'b00;
  logic            req_dirty = 1'b0;
  logic [DW/8-1:0] req_wstrb = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic [DW-1:0]   req_odata = '0;
  logic [DW-1:0]   req_fix = '0;
  logic [2*NG-1:0] req_chk = '0;
  logic            defer_en = 1'b0;
  logic            ierr_en = 1'b0;
  logic            rsp_valid;
  logic [1:0]      rsp_code;
  logic [DW-1:0]   rsp_data;
  logic [NG-1:0]   rsp_poison;
  logic [NG-1:0]   rsp_gwe;
  logic            evt_valid;
  logic [1:0]      evt_class;

  always #5 clk = ~clk;

  mer_resp_unit #(.DW(DW), .GW(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_dirty(req_dirty), .req_wstrb(req_wstrb), .req_wdata(req_wdata),
    .req_odata(req_odata), .req_fix(req_fix), .req_chk(req_chk),
    .defer_en(defer_en), .ierr_en(ierr_en), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_data(rsp_data), .rsp_poison(rsp_poison),
    .rsp_gwe(rsp_gwe), .evt_valid(evt_valid), .evt_class(evt_class)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // expectation for the next falling edge
  logic            e_valid = 0;
  logic [1:0]      e_code = 0;
  logic [DW-1:0]   e_data = 0;
  logic [NG-1:0]   e_poison = 0;
  logic [NG-1:0]   e_gwe = 0;
  logic            e_evt = 0;
  logic [1:0]      e_cls = 0;
  string           e_tag = "R13";

  task automatic compare();
    bit bad;
    checks++;
    bad = (rsp_valid !== e_valid) || (rsp_code !== e_code) ||
          (rsp_poison !== e_poison) || (rsp_gwe !== e_gwe) ||
          (evt_valid !== e_evt) || (evt_class !== e_cls) ||
          (e_valid && rsp_data !== e_data);
    if (bad) begin
      failures++;
      $display("FAIL %s: got v=%0h code=%0h pois=%0h gwe=%0h evt=%0h cls=%0h data=%h exp v=%0h code=%0h pois=%0h gwe=%0h evt=%0h cls=%0h data=%h",
               e_tag, rsp_valid, rsp_code, rsp_poison, rsp_gwe, evt_valid, evt_class, rsp_data,
               e_valid, e_code, e_poison, e_gwe, e_evt, e_cls, e_data);
    end
  endtask

  // behavioural model of the requirements
  task automatic predict();
    int wc, wk;
    e_valid = req_valid;
    e_code = 0; e_poison = 0; e_gwe = 0; e_evt = 0; e_cls = 0; e_data = 0;
    if (!req_valid) return;
    wc = 0; wk = 0;
    for (int g = 0; g < NG; g++) begin
      logic [31:0] o, f, w, fo, d;
      logic [3:0]  s;
      int ck, code, cls;
      bit we, unc;
      o = req_odata[g*32 +: 32]; f = req_fix[g*32 +: 32]; w = req_wdata[g*32 +: 32];
      s = req_wstrb[g*4 +: 4]; ck = int'(req_chk[g*2 +: 2]);
      unc = (ck >= 2);
      fo = (ck == 1) ? (o ^ f) : o;
      code = 0; cls = 0; we = 0; d = fo;
      if (req_op == 2'b01) begin
        if (s == 4'h0) d = o;
        else if (s == 4'hF) begin we = 1; d = w; end
        else begin
          we = 1;
          for (int b = 0; b < 4; b++) d[b*8 +: 8] = s[b] ? w[b*8 +: 8] : fo[b*8 +: 8];
          if (ck == 1) begin code = 1; cls = 1; end
          else if (unc) begin
            if (defer_en) begin code = 2; cls = 2; end
            else if (ierr_en) begin code = 3; cls = 3; we = 0; d = 0; end
            else begin code = 2; cls = 3; end
          end
        end
      end else if (req_op == 2'b10) begin
        if (req_dirty) begin
          we = 1;
          if (ck == 1) begin code = 1; cls = 1; end
          else if (unc) begin code = 2; cls = 2; end
        end else d = o;
      end else begin
        if (ck == 1) begin code = 1; cls = 1; end
        else if (unc) begin
          if (defer_en) begin code = 2; cls = 2; end
          else if (ierr_en) begin code = 3; cls = 3; d = 0; end
          else begin code = 2; cls = 3; end
        end
      end
      e_data[g*32 +: 32] = d;
      e_gwe[g] = we;
      e_poison[g] = (code == 2);
      if (code > wc) wc = code;
      if (cls > wk) wk = cls;
    end
    e_code = 2'(wc);
    e_evt = (wk != 0);
    e_cls = 2'(wk);
  endtask

  task automatic step(input bit v, input logic [1:0] op, input bit dirty,
                      input logic [7:0] strb, input logic [63:0] wd,
                      input logic [63:0] od, input logic [63:0] fx,
                      input logic [3:0] ck, input bit dfr, input bit ie,
                      input string tag);
    @(negedge clk);
    compare();
    req_valid = v; req_op = op; req_dirty = dirty; req_wstrb = strb;
    req_wdata = wd; req_odata = od; req_fix = fx; req_chk = ck;
    defer_en = dfr; ierr_en = ie;
    predict();
    e_tag = tag;
  endtask

  localparam logic [63:0] OD = 64'hA5A5_1234_5A5A_CDEF;
  localparam logic [63:0] WD = 64'h0102_0304_0506_0708;
  localparam logic [63:0] FX = 64'h0000_0100_0000_0010;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_tag = "R13";
    // R13 reset state and idle
    step(0, 2'b00, 0, 8'h00, 0, 0, 0, 4'h0, 0, 0, "R13");
    // R1 clean read
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b0000, 1, 1, "R1");
    // R2 correctable read in granule 0
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b0001, 1, 1, "R2");
    // R3 uncorrectable read in granule 1, deferral on
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b1000, 1, 1, "R3");
    // R4 uncorrectable, no deferral, in-band on
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b0010, 0, 1, "R4");
    // R5 both disabled -> poisoned, UE
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b1100, 0, 0, "R5");
    // R6 partial write over correctable granule 0
    step(1, 2'b01, 0, 8'h03, WD, OD, FX, 4'b0001, 1, 1, "R6");
    // R7 partial write uncorrectable, deferral on
    step(1, 2'b01, 0, 8'h60, WD, OD, FX, 4'b1000, 1, 1, "R7");
    // R7 partial write uncorrectable, both off
    step(1, 2'b01, 0, 8'h01, WD, OD, FX, 4'b0011, 0, 0, "R7");
    // R8 partial write uncorrectable, in-band on
    step(1, 2'b01, 0, 8'h01, WD, OD, FX, 4'b0010, 0, 1, "R8");
    // R9 full granule 0 over uncorrectable, granule 1 unstrobed uncorrectable
    step(1, 2'b01, 0, 8'h0F, WD, OD, FX, 4'b1010, 0, 1, "R9");
    // R10 dirty eviction, uncorrectable, in-band on and deferral off
    step(1, 2'b10, 1, 8'h00, WD, OD, FX, 4'b1001, 0, 1, "R10");
    // R11 clean eviction with uncorrectable check
    step(1, 2'b10, 0, 8'h00, WD, OD, FX, 4'b1010, 0, 1, "R11");
    // R12 mixed granules: corrected + aborted
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b1001, 0, 1, "R12");
    // R12 mixed granules: corrected + deferred
    step(1, 2'b00, 0, 8'h00, WD, OD, FX, 4'b0110, 1, 0, "R12");
    // R13 idle gap after a request
    step(0, 2'b00, 0, 8'h00, WD, OD, FX, 4'b1111, 1, 1, "R13");
    step(0, 2'b00, 0, 8'h00, WD, OD, FX, 4'b1111, 1, 1, "R13");
    // R12 random mixture of outcomes
    for (int i = 0; i < 400; i++) begin
      logic [1:0] rop;
      rop = 2'($urandom_range(0, 2));
      step(1'($urandom_range(0, 3) != 0), rop, 1'($urandom),
           8'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, 4'($urandom), 1'($urandom), 1'($urandom), "R12");
    end
    step(0, 2'b00, 0, 8'h00, 0, 0, 0, 4'h0, 0, 0, "R13");
    step(0, 2'b00, 0, 8'h00, 0, 0, 0, 4'h0, 0, 0, "R13");
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule